// File: doc/BRIEF.md
# Flash Command Sequencer with Forced Stop

This block runs the long flash commands of a small on-chip flash controller. There are three commands: word programming, blank checking and block erasure. Software places a 20-bit start address and a 20-bit end address in two halves each. It then writes a control byte that holds a start bit, a stop bit and a command code. The engine walks the range one 4-byte word per clock cycle. For each word it raises a request to a memory model port, and the port answers in the same cycle with a single pass/fail bit.

A run ends in one of three ways: the last word passes, a word fails, or software forces a stop. In all three cases the ready flag rises. A monitor register shows where the run ended. After a forced stop it holds the first word not yet visited, so a stopped blank check can resume by copying the monitor into the start address. Software clears ready by writing a control byte with the start bit at 0. A flash-reset input abandons any run and clears every flag.

Top module: `flashCmdEngine`

## Requirements
- R1: The start address is {startHi, startLo} and the end address is {endHi, endLo}. The two low bits of each are ignored, so both are rounded down to a word boundary.
- R2: The control byte places the start bit at bit 7 and the stop bit at bit 6. The command code sits in bits 2:0, with 001 for program, 010 for blank check and 100 for block erase. A run begins on the write that loads this byte.
- R3: Starting on the cycle after that write, memReq is high for one cycle per word. memAddr rises by 4 each cycle from the aligned start address, and memCmd carries the command code. memReq is low whenever no run is active.
- R4: On normal completion rdy becomes 1 and monAddr holds the last word processed. This is the aligned end address, or the start word when end is below start. No error flag is set.
- R5: When memFail is high during a program or blank check, the run ends at once. errPrg or errBlank is set, rdy becomes 1 and monAddr holds the failing word.
- R6: When memFail is high during a block erase, the run ends at once. errErase is set, rdy becomes 1 and monAddr holds the aligned start address of the block.
- R7: A control write with bit 7 at 0 while no run is active clears rdy on the next cycle.
- R8: A control write with the stop bit while a run is active ends the run at that edge. No memory access happens in that cycle, rdy becomes 1, no error flag is set, and monAddr holds the first word not yet processed.
- R9: A blank check restarted with the monitor value as its start address visits exactly the words it had not yet visited. On a clean range it finishes with monAddr at the end word.
- R10: A start write is ignored while rdy is 1 or while a run is active.
- R11: flashRst clears rdy and all error flags on the next edge and abandons any active run. monAddr is then undefined until the next run completes.
- R12: A start write whose command code is not one of the three defined codes is ignored.
- R13: Bits 1:0 of monAddr are always 00, and the error flags are cleared when a new run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flashRst | input | 1 | Synchronous flash reset: abandons a run, clears flags |
| ctrlWe | input | 1 | Control byte write strobe |
| ctrlWdata | input | 8 | Control byte: bit7 start, bit6 stop, bits2:0 command |
| startHi | input | 4 | Start address bits 19:16 |
| startLo | input | 16 | Start address bits 15:0 |
| endHi | input | 4 | End address bits 19:16 |
| endLo | input | 16 | End address bits 15:0 |
| memReq | output | 1 | Word access request to the memory model |
| memAddr | output | 20 | Word address of the access |
| memCmd | output | 3 | Command code of the active run |
| memFail | input | 1 | Same-cycle response: word failed (non-blank, or write/erase failure) |
| rdy | output | 1 | Run finished (normal, error or forced stop) |
| errPrg | output | 1 | Program error |
| errBlank | output | 1 | Blank-check error (non-blank word found) |
| errErase | output | 1 | Block erase error |
| monAddr | output | 20 | Last, failing, block-start or stop-point address |

## Verification
The engine is driven with a clean program run over a misaligned start, and with a blank check that fails mid-range. An erase that fails deep inside its block separates the failing-word monitor rule from the block-start rule. A blank check is stopped after five words and then resumed from the monitor. This shows that the stop point is the first unvisited word, so no word is skipped and none is visited twice. Start writes made while the engine is busy, while ready is still set, or with an undefined command code show that each is refused. A flash reset that follows an erase error and another that lands mid-run show that flags and activity are abandoned.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;
  localparam int CTRL_START = 7;
  localparam int CTRL_STOP  = 6;
  localparam int CMD_W      = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE  = 3'b000,
    CMD_PROG  = 3'b001,
    CMD_BLANK = 3'b010,
    CMD_ERASE = 3'b100
  } cmdE;

  typedef struct packed {
    logic load;
    logic advance;
    logic capCur;
    logic capBase;
    logic wipe;
  } strobeT;
endpackage

// File: rtl/flashSeqPath.sv
module flashSeqPath
  import flashSeqPkg::*;
#(
  parameter int HI_W = 4,
  parameter int LO_W = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               stb,
  input  logic [HI_W-1:0]      startHi,
  input  logic [LO_W-1:0]      startLo,
  input  logic [HI_W-1:0]      endHi,
  input  logic [LO_W-1:0]      endLo,
  output logic [HI_W+LO_W-1:0] curAddr,
  output logic                 atEnd,
  output logic [HI_W+LO_W-1:0] monAddr
);
  localparam int ADDR_W = HI_W + LO_W;
  localparam int ALIGN  = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] alignedStart, alignedEnd, endWord, baseWord;

  assign alignedStart = {startHi, startLo[LO_W-1:ALIGN], {ALIGN{1'b0}}};
  assign alignedEnd   = {endHi, endLo[LO_W-1:ALIGN], {ALIGN{1'b0}}};
  assign atEnd        = curAddr >= endWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      endWord  <= '0;
      baseWord <= '0;
      monAddr  <= '0;
    end else begin
      if (stb.load) begin
        curAddr  <= alignedStart;
        baseWord <= alignedStart;
        endWord  <= alignedEnd;
      end else if (stb.advance) begin
        curAddr <= curAddr + STEP;
      end
      if (stb.wipe)         monAddr <= '0;
      else if (stb.capCur)  monAddr <= curAddr;
      else if (stb.capBase) monAddr <= baseWord;
    end
  end
endmodule

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             flashRst,
  input  logic             ctrlWe,
  input  logic [7:0]       ctrlWdata,
  input  logic             memFail,
  input  logic             atEnd,
  output strobeT           stb,
  output logic             memReq,
  output logic [CMD_W-1:0] memCmd,
  output logic             rdy,
  output logic             errPrg,
  output logic             errBlank,
  output logic             errErase
);
  logic busy;
  cmdE  cmd;
  logic cmdOk, startNow, stopNow, access, failNow, doneNow;
  cmdE  reqCmd;

  assign reqCmd   = cmdE'(ctrlWdata[CMD_W-1:0]);
  assign cmdOk    = (reqCmd == CMD_PROG) || (reqCmd == CMD_BLANK) || (reqCmd == CMD_ERASE);
  assign startNow = !flashRst && !busy && !rdy && ctrlWe && ctrlWdata[CTRL_START] && cmdOk;
  assign stopNow  = !flashRst && busy && ctrlWe && ctrlWdata[CTRL_STOP];
  assign access   = !flashRst && busy && !stopNow;
  assign failNow  = access && memFail;
  assign doneNow  = access && !memFail && atEnd;

  always_comb begin
    stb         = '0;
    stb.load    = startNow;
    stb.advance = access && !memFail && !atEnd;
    stb.capCur  = stopNow || doneNow || (failNow && cmd != CMD_ERASE);
    stb.capBase = failNow && cmd == CMD_ERASE;
    stb.wipe    = flashRst;
  end

  assign memReq = access;
  assign memCmd = cmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cmd      <= CMD_NONE;
      rdy      <= 1'b0;
      errPrg   <= 1'b0;
      errBlank <= 1'b0;
      errErase <= 1'b0;
    end else if (flashRst) begin
      busy     <= 1'b0;
      rdy      <= 1'b0;
      errPrg   <= 1'b0;
      errBlank <= 1'b0;
      errErase <= 1'b0;
    end else if (startNow) begin
      busy     <= 1'b1;
      cmd      <= reqCmd;
      errPrg   <= 1'b0;
      errBlank <= 1'b0;
      errErase <= 1'b0;
    end else if (busy) begin
      if (stopNow || doneNow) begin
        busy <= 1'b0;
        rdy  <= 1'b1;
      end else if (failNow) begin
        busy     <= 1'b0;
        rdy      <= 1'b1;
        errPrg   <= cmd == CMD_PROG;
        errBlank <= cmd == CMD_BLANK;
        errErase <= cmd == CMD_ERASE;
      end
    end else if (ctrlWe && !ctrlWdata[CTRL_START]) begin
      rdy <= 1'b0;
    end
  end
endmodule

// File: rtl/flashCmdEngine.sv
module flashCmdEngine
  import flashSeqPkg::*;
#(
  parameter int HI_W = 4,
  parameter int LO_W = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flashRst,
  input  logic                 ctrlWe,
  input  logic [7:0]           ctrlWdata,
  input  logic [HI_W-1:0]      startHi,
  input  logic [LO_W-1:0]      startLo,
  input  logic [HI_W-1:0]      endHi,
  input  logic [LO_W-1:0]      endLo,
  output logic                 memReq,
  output logic [HI_W+LO_W-1:0] memAddr,
  output logic [2:0]           memCmd,
  input  logic                 memFail,
  output logic                 rdy,
  output logic                 errPrg,
  output logic                 errBlank,
  output logic                 errErase,
  output logic [HI_W+LO_W-1:0] monAddr
);
  strobeT stb;
  logic   atEnd;

  flashSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .flashRst(flashRst),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .memFail(memFail), .atEnd(atEnd), .stb(stb),
    .memReq(memReq), .memCmd(memCmd), .rdy(rdy),
    .errPrg(errPrg), .errBlank(errBlank), .errErase(errErase)
  );

  flashSeqPath #(.HI_W(HI_W), .LO_W(LO_W), .WORD_BYTES(WORD_BYTES)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .startHi(startHi), .startLo(startLo), .endHi(endHi), .endLo(endLo),
    .curAddr(memAddr), .atEnd(atEnd), .monAddr(monAddr)
  );
endmodule

// File: rtl/flashCmdEngineChecker.sv
module flashCmdEngineChecker #(
  parameter int ADDR_W = 20,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              flashRst,
  input logic              ctrlWe,
  input logic [7:0]        ctrlWdata,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rdy,
  input logic              errPrg,
  input logic              errBlank,
  input logic              errErase,
  input logic [ADDR_W-1:0] monAddr
);
  localparam int ALIGN = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  AST_RDY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rdy |-> !memReq); // R10
  AST_MON_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    monAddr[ALIGN-1:0] == '0); // R13
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({errPrg, errBlank, errErase}) <= 1); // R5
  AST_WORD_WALK: assert property (@(posedge clk) disable iff (!rstN)
    memReq && $past(memReq) |-> memAddr == $past(memAddr) + STEP); // R3
  AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    rdy && ctrlWe && !ctrlWdata[7] |=> !rdy); // R7
  AST_FLASH_RESET: assert property (@(posedge clk) disable iff (!rstN)
    flashRst |=> !rdy && !errPrg && !errBlank && !errErase && !memReq); // R11
  AST_STOP_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlWdata[6] && !flashRst && !rdy && $past(memReq) |=>
      rdy && !errPrg && !errBlank && !errErase); // R8
endmodule

bind flashCmdEngine flashCmdEngineChecker #(.ADDR_W(HI_W + LO_W), .WORD_BYTES(WORD_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .flashRst(flashRst), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
  .memReq(memReq), .memAddr(memAddr), .rdy(rdy), .errPrg(errPrg),
  .errBlank(errBlank), .errErase(errErase), .monAddr(monAddr)
);

// File: tb/flashCmdEngine_bench.sv
`timescale 1ns/1ps
module flashCmdEngine_bench;
  logic clk = 0;
  logic rstN = 0;
  logic flashRst = 0;
  logic ctrlWe = 0;
  logic [7:0] ctrlWdata = 0;
  logic [3:0] startHi = 0, endHi = 0;
  logic [15:0] startLo = 0, endLo = 0;
  logic memReq, memFail, rdy, errPrg, errBlank, errErase;
  logic [19:0] memAddr, monAddr;
  logic [2:0] memCmd;
  logic failEn = 0;
  logic [19:0] failAddr = 0;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  assign memFail = failEn && memReq && (memAddr == failAddr);

  flashCmdEngine u_flashCmdEngine (
    .clk(clk), .rstN(rstN), .flashRst(flashRst), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .startHi(startHi), .startLo(startLo), .endHi(endHi), .endLo(endLo),
    .memReq(memReq), .memAddr(memAddr), .memCmd(memCmd), .memFail(memFail),
    .rdy(rdy), .errPrg(errPrg), .errBlank(errBlank), .errErase(errErase), .monAddr(monAddr)
  );

  // behavioural reference model
  bit mBusy, mRdy, mPrg, mBlank, mErase, monDc;
  int mCmd, mCur, mEnd, mBase, mMon;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mRdy = 0; mPrg = 0; mBlank = 0; mErase = 0; mMon = 0; monDc = 0; mCmd = 0;
    end else if (flashRst) begin
      mBusy = 0; mRdy = 0; mPrg = 0; mBlank = 0; mErase = 0; monDc = 1;
    end else if (mBusy) begin
      if (ctrlWe && ctrlWdata[6]) begin
        mBusy = 0; mRdy = 1; mMon = mCur; monDc = 0;
      end else if (failEn && mCur == int'(failAddr)) begin
        mBusy = 0; mRdy = 1; monDc = 0;
        mPrg = (mCmd == 1); mBlank = (mCmd == 2); mErase = (mCmd == 4);
        mMon = (mCmd == 4) ? mBase : mCur;
      end else if (mCur >= mEnd) begin
        mBusy = 0; mRdy = 1; mMon = mCur; monDc = 0;
      end else begin
        mCur = mCur + 4;
      end
    end else if (ctrlWe) begin
      if (!ctrlWdata[7]) mRdy = 0;
      else if (!mRdy && (ctrlWdata[2:0] == 1 || ctrlWdata[2:0] == 2 || ctrlWdata[2:0] == 4)) begin
        mBusy = 1; mCmd = ctrlWdata[2:0];
        mCur = ({startHi, startLo} / 4) * 4; mBase = mCur;
        mEnd = ({endHi, endLo} / 4) * 4;
        mPrg = 0; mBlank = 0; mErase = 0;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rstN) begin
      bit expReq;
      expReq = mBusy && !(ctrlWe && ctrlWdata[6]) && !flashRst;
      chk("R3 memReq", memReq, expReq);
      if (expReq) begin
        chk("R1 R3 memAddr", memAddr, mCur);
        chk("R2 memCmd", memCmd, mCmd);
      end
      chk("R4 rdy", rdy, mRdy);
      chk("R5 errPrg", errPrg, mPrg);
      chk("R5 errBlank", errBlank, mBlank);
      chk("R6 errErase", errErase, mErase);
      if (!monDc) chk("R4 R13 monAddr", monAddr, mMon);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); ctrlWe = 1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 0; ctrlWdata = 0;
  endtask

  task automatic setRange(input logic [19:0] s, input logic [19:0] e);
    @(negedge clk);
    {startHi, startLo} = s; {endHi, endLo} = e;
  endtask

  task automatic waitRdy();
    for (int i = 0; i < 2000 && !rdy; i++) @(negedge clk);
  endtask

  initial begin
    tick(3);
    rstN = 1;
    tick(1);
    #2;
    chk("R11 reset rdy", rdy, 0);
    chk("R3 reset memReq", memReq, 0);

    // clean program run with misaligned start
    setRange(20'h1_0002, 20'h1_001E);
    wr(8'h81);
    waitRdy(); #2;
    chk("R4 program done mon", monAddr, 20'h1_001C);
    chk("R4 program no error", errPrg, 0);
    wr(8'h00); #2;
    chk("R7 rdy cleared", rdy, 0);

    // blank check failing mid-range
    failEn = 1; failAddr = 20'h2_0010;
    setRange(20'h2_0000, 20'h2_00FC);
    wr(8'h82);
    waitRdy(); #2;
    chk("R5 blank error flag", errBlank, 1);
    chk("R5 blank error mon", monAddr, 20'h2_0010);
    wr(8'h00);

    // erase failing deep inside the block, then flash reset clears flags
    failAddr = 20'h3_0100;
    setRange(20'h3_0000, 20'h3_03FC);
    wr(8'h84);
    waitRdy(); #2;
    chk("R6 erase error flag", errErase, 1);
    chk("R6 erase mon block start", monAddr, 20'h3_0000);
    @(negedge clk); flashRst = 1;
    @(negedge clk); flashRst = 0; #2;
    chk("R11 flags cleared", errErase, 0);
    chk("R11 rdy cleared", rdy, 0);
    failEn = 0;

    // forced stop of a blank check after five words, then resume
    setRange(20'h4_0000, 20'h4_00FC);
    wr(8'h82);
    tick(4);
    wr(8'h40); #2;
    chk("R8 stop rdy", rdy, 1);
    chk("R8 stop point", monAddr, 20'h4_0014);
    chk("R8 no blank flag", errBlank, 0);
    wr(8'h82); tick(3); #2;
    chk("R10 start ignored while rdy", memReq, 0);
    chk("R10 rdy held", rdy, 1);
    wr(8'h00);
    setRange(monAddr, 20'h4_00FC);
    wr(8'h82);
    waitRdy(); #2;
    chk("R9 resume end", monAddr, 20'h4_00FC);
    chk("R9 resume clean", errBlank, 0);
    wr(8'h00);

    // start write while busy is ignored
    setRange(20'h5_0000, 20'h5_003C);
    wr(8'h82);
    tick(2);
    wr(8'h81);
    waitRdy(); #2;
    chk("R10 busy restart ignored", monAddr, 20'h5_003C);
    wr(8'h00);

    // end below start: single word
    setRange(20'h5_1000, 20'h5_0000);
    wr(8'h81);
    waitRdy(); #2;
    chk("R4 end below start", monAddr, 20'h5_1000);
    wr(8'h00);

    // undefined command code
    setRange(20'h7_0000, 20'h7_0010);
    wr(8'h83); tick(3); #2;
    chk("R12 bad code no access", memReq, 0);
    chk("R12 bad code no rdy", rdy, 0);

    // flash reset mid-run
    setRange(20'h6_0000, 20'h6_03FC);
    wr(8'h84);
    tick(3);
    @(negedge clk); flashRst = 1;
    @(negedge clk); flashRst = 0; #2;
    chk("R11 run abandoned", memReq, 0);
    chk("R11 no rdy", rdy, 0);
    tick(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule